// File: doc/BRIEF.md
# DRAM ECC Error Status and Log Capture

This block sits beside the ECC checkers of a two-channel DRAM controller. Each checker reports, per cycle, whether it saw a correctable (single-bit) or an uncorrectable (multi-bit) error. It also reports the column, row, bank and rank of the failing access and the 8-bit syndrome. The block folds those reports into a two-bit sticky status register and keeps a 64-bit log for each channel. Software reads both through a small register port and acknowledges errors by writing ones to the status flags.

Uncorrectable errors take precedence. An uncorrectable error may replace a log that holds only a correctable error. A log holding an uncorrectable error is frozen until software clears the uncorrectable flag. A correctable error is recorded only into an empty log. An interrupt stays high while any flag is set. A strap input marks the controller as single-channel, and then every report from channel 1 is ignored.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset the status register, both logs and `irq` read as zero.
- R2: A correctable report on an enabled channel sets status bit 0, and an uncorrectable report sets status bit 1. Status bits 15:2 always read as zero.
- R3: A register write to address 0 clears each status flag whose write-data bit is 1 and leaves a flag whose write-data bit is 0 unchanged.
- R4: Log layout: bit 0 correctable-valid, bit 1 uncorrectable-valid, bits 23:16 syndrome, bits 28:27 rank, bits 31:29 bank, bits 47:32 row, bits 63:48 column. Bits 26:24 and 15:2 are zero. Address 1 reads the channel 0 log, address 2 reads the channel 1 log, and address 3 reads zero.
- R5: A correctable report is captured into a channel's log only when both of that log's valid bits are clear.
- R6: An uncorrectable report replaces a log that holds a correctable error. The new log has bit 1 set, bit 0 clear and all fields from the new report.
- R7: While a log's bit 1 is set, no further report on that channel changes the log.
- R8: Clearing status bit 0 clears bit 0 of both logs, and clearing status bit 1 clears bit 1 of both logs. The other log fields are kept.
- R9: `irq` is high exactly while status bit 0 or bit 1 is set.
- R10: While `single_chan` is 1, channel 1 reports change neither the channel 1 log nor the status.
- R11: When a capture or a flag set coincides with a clearing write, the capture and the set take effect.
- R12: Simultaneous correctable and uncorrectable reports on one channel are logged as uncorrectable and set both status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| single_chan | input | 1 | Strap: 1 ignores channel 1 reports |
| ev_ce | input | 2 | Correctable error report, one bit per channel |
| ev_ue | input | 2 | Uncorrectable error report, one bit per channel |
| ev_col | input | 32 | Column address, 16 bits per channel (channel 1 in the upper half) |
| ev_row | input | 32 | Row address, 16 bits per channel |
| ev_bank | input | 6 | Bank, 3 bits per channel |
| ev_rank | input | 4 | Rank, 2 bits per channel |
| ev_syn | input | 16 | Syndrome, 8 bits per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 log 0, 2 log 1 |
| reg_wdata | input | 16 | Write data (status write-one-to-clear mask) |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Error interrupt |

## Verification
A vector table drives channel 0 through correctable-then-correctable, correctable-then-uncorrectable and uncorrectable-then-anything sequences. These show whether a correctable error was wrongly allowed to overwrite a log and whether an uncorrectable log stayed frozen. Writes of zero masks, single-flag masks and full masks separate write-one-to-clear from plain write behaviour and test the clearing of log valid bits. Cycles that carry a capture and a clear together show which one the design favours. Directed tests then drive channel 1 with the strap low and high, read the unused address, and write all ones to status to expose any stray status bits.

// File: rtl/ecc_err_capture.sv
module ecc_err_capture #(
  parameter int COL_W = 16,
  parameter int ROW_W = 16,
  parameter int BANK_W = 3,
  parameter int RANK_W = 2,
  parameter int SYN_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 single_chan,
  input  logic [1:0]           ev_ce,
  input  logic [1:0]           ev_ue,
  input  logic [2*COL_W-1:0]   ev_col,
  input  logic [2*ROW_W-1:0]   ev_row,
  input  logic [2*BANK_W-1:0]  ev_bank,
  input  logic [2*RANK_W-1:0]  ev_rank,
  input  logic [2*SYN_W-1:0]   ev_syn,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [15:0]          reg_wdata,
  output logic [63:0]          reg_rdata,
  output logic                 irq
);
  localparam int NCH = 2;

  logic [1:0]  st;
  logic [63:0] log0, log1;
  logic [1:0]  clr;
  logic [NCH-1:0] en, ce_in, ue_in;

  assign en    = {~single_chan, 1'b1};
  assign ce_in = ev_ce & en;
  assign ue_in = ev_ue & en;
  assign clr   = (reg_wr && reg_addr == 2'd0) ? reg_wdata[1:0] : 2'b00;

  function automatic logic [63:0] pack(input logic [COL_W-1:0] c, input logic [ROW_W-1:0] r,
                                       input logic [BANK_W-1:0] b, input logic [RANK_W-1:0] k,
                                       input logic [SYN_W-1:0] s, input logic ue);
    return {c, r, b, k, 3'b000, s, 14'd0, ue, ~ue};
  endfunction

  logic [63:0] nxt [NCH];
  logic [63:0] cur [NCH];
  assign cur[0] = log0;
  assign cur[1] = log1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic cap_ue, cap_ce;
    assign cap_ue = ue_in[c] && !cur[c][1];
    assign cap_ce = ce_in[c] && !ue_in[c] && !cur[c][1] && !cur[c][0];
    always_comb begin
      nxt[c] = cur[c];
      if (cap_ue || cap_ce)
        nxt[c] = pack(ev_col[c*COL_W +: COL_W], ev_row[c*ROW_W +: ROW_W],
                      ev_bank[c*BANK_W +: BANK_W], ev_rank[c*RANK_W +: RANK_W],
                      ev_syn[c*SYN_W +: SYN_W], cap_ue);
      else
        nxt[c][1:0] = cur[c][1:0] & ~clr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= '0;
      log0 <= '0;
      log1 <= '0;
    end else begin
      st   <= (st & ~clr) | {|ue_in, |ce_in};
      log0 <= nxt[0];
      log1 <= nxt[1];
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {62'd0, st};
      2'd1:    reg_rdata = log0;
      2'd2:    reg_rdata = log1;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = |st;
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        single_chan,
  input logic [1:0]  ev_ce,
  input logic [1:0]  ev_ue,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic [1:0]  st,
  input logic [63:0] log0,
  input logic [63:0] log1,
  input logic        irq
);
  logic wst;
  assign wst = reg_wr && reg_addr == 2'd0;

  p_w1c_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st[0] && !(wst && reg_wdata[0]) |=> st[0]);

  p_ce_no_overwrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    log0[0] && !ev_ue[0] && !(wst && reg_wdata[0]) |=> $stable(log0));

  p_ue_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    log0[1] && !(wst && reg_wdata[1]) |=> log0[1] && $stable(log0));

  p_clear_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wst && reg_wdata[0] && ev_ce == 2'b00 |=> !st[0] && !log0[0] && !log1[0]);

  p_irq_on_error_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ue[0] |=> irq);

  p_chan1_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    single_chan && !wst |=> $stable(log1));
endmodule

bind ecc_err_capture ecc_err_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .single_chan(single_chan), .ev_ce(ev_ce), .ev_ue(ev_ue),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .st(st), .log0(log0), .log1(log1), .irq(irq)
);

// File: tb/sim_ecc_err_capture.sv
module sim_ecc_err_capture;
  logic clk = 0, rst_n = 0, single_chan = 0;
  logic [1:0] ev_ce = 0, ev_ue = 0, reg_addr = 0;
  logic [31:0] ev_col = 0, ev_row = 0;
  logic [5:0] ev_bank = 0;
  logic [3:0] ev_rank = 0;
  logic [15:0] ev_syn = 0, reg_wdata = 0;
  logic reg_wr = 0;
  logic [63:0] reg_rdata;
  logic irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ecc_err_capture u0 (.*);

  function automatic logic [63:0] pk(input logic [15:0] c, input logic [15:0] r, input logic [2:0] b,
                                     input logic [1:0] k, input logic [7:0] s, input logic [1:0] v);
    return {c, r, b, k, 3'b000, s, 14'd0, v};
  endfunction

  typedef struct packed {
    logic ce; logic ue; logic wr; logic [1:0] msk;
    logic [15:0] col; logic [15:0] row; logic [2:0] bank; logic [1:0] rank; logic [7:0] syn;
    logic [1:0] est; logic [63:0] elog;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t V [NV] = '{
    '{1,0,0,2'b00,16'h1234,16'h5678,3'd5,2'd2,8'hA5,2'b01,pk(16'h1234,16'h5678,3'd5,2'd2,8'hA5,2'b01)},
    '{1,0,0,2'b00,16'h1111,16'h2222,3'd1,2'd1,8'h11,2'b01,pk(16'h1234,16'h5678,3'd5,2'd2,8'hA5,2'b01)},
    '{0,1,0,2'b00,16'hC0C0,16'h0C0C,3'd7,2'd3,8'h3C,2'b11,pk(16'hC0C0,16'h0C0C,3'd7,2'd3,8'h3C,2'b10)},
    '{1,0,0,2'b00,16'hDDDD,16'hDDDD,3'd2,2'd0,8'hDD,2'b11,pk(16'hC0C0,16'h0C0C,3'd7,2'd3,8'h3C,2'b10)},
    '{0,1,0,2'b00,16'hEEEE,16'hEEEE,3'd3,2'd1,8'hEE,2'b11,pk(16'hC0C0,16'h0C0C,3'd7,2'd3,8'h3C,2'b10)},
    '{0,0,1,2'b01,16'h0,16'h0,3'd0,2'd0,8'h0,2'b10,pk(16'hC0C0,16'h0C0C,3'd7,2'd3,8'h3C,2'b10)},
    '{0,0,1,2'b10,16'h0,16'h0,3'd0,2'd0,8'h0,2'b00,pk(16'hC0C0,16'h0C0C,3'd7,2'd3,8'h3C,2'b00)},
    '{1,0,0,2'b00,16'hF00D,16'hBEEF,3'd4,2'd1,8'h5A,2'b01,pk(16'hF00D,16'hBEEF,3'd4,2'd1,8'h5A,2'b01)},
    '{0,0,1,2'b00,16'h0,16'h0,3'd0,2'd0,8'h0,2'b01,pk(16'hF00D,16'hBEEF,3'd4,2'd1,8'h5A,2'b01)},
    '{0,0,1,2'b11,16'h0,16'h0,3'd0,2'd0,8'h0,2'b00,pk(16'hF00D,16'hBEEF,3'd4,2'd1,8'h5A,2'b00)},
    '{0,1,1,2'b10,16'h4242,16'h2424,3'd6,2'd2,8'h81,2'b10,pk(16'h4242,16'h2424,3'd6,2'd2,8'h81,2'b10)},
    '{0,0,1,2'b11,16'h0,16'h0,3'd0,2'd0,8'h0,2'b00,pk(16'h4242,16'h2424,3'd6,2'd2,8'h81,2'b00)},
    '{1,1,0,2'b00,16'h7777,16'h9999,3'd1,2'd3,8'h77,2'b11,pk(16'h7777,16'h9999,3'd1,2'd3,8'h77,2'b10)}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, d); chk("R1 status", d, 0);
    rd(1, d); chk("R1 log0", d, 0);
    rd(2, d); chk("R1 log1", d, 0);
    chk("R1 irq", {63'd0, irq}, 0);

    for (int i = 0; i < NV; i++) begin
      ev_ce[0] = V[i].ce; ev_ue[0] = V[i].ue;
      ev_col[15:0] = V[i].col; ev_row[15:0] = V[i].row; ev_bank[2:0] = V[i].bank;
      ev_rank[1:0] = V[i].rank; ev_syn[7:0] = V[i].syn;
      reg_wr = V[i].wr; reg_addr = 0; reg_wdata = {14'd0, V[i].msk};
      @(negedge clk);
      ev_ce = 0; ev_ue = 0; reg_wr = 0;
      rd(0, d); chk("R2 R3 R11 R12 status", d, {62'd0, V[i].est});
      rd(1, d); chk("R4 R5 R6 R7 R8 log0", d, V[i].elog);
      chk("R9 irq", {63'd0, irq}, {63'd0, |V[i].est});
    end

    reg_wr = 1; reg_addr = 0; reg_wdata = 16'hFFFF;
    @(negedge clk); reg_wr = 0;
    ev_ce[1] = 1; ev_col[31:16] = 16'hAB12; ev_row[31:16] = 16'h34CD;
    ev_bank[5:3] = 3'd2; ev_rank[3:2] = 2'd1; ev_syn[15:8] = 8'hC3;
    @(negedge clk); ev_ce = 0;
    rd(2, d); chk("R4 log1 channel 1 CE", d, pk(16'hAB12, 16'h34CD, 3'd2, 2'd1, 8'hC3, 2'b01));
    rd(0, d); chk("R2 status from ch1", d, 64'd1);

    reg_wr = 1; reg_addr = 0; reg_wdata = 16'hFFFF;
    @(negedge clk); reg_wr = 0;
    rd(0, d); chk("R2 upper status bits zero", d, 0);
    rd(2, d); chk("R8 log1 valid cleared", d, pk(16'hAB12, 16'h34CD, 3'd2, 2'd1, 8'hC3, 2'b00));

    single_chan = 1;
    ev_ue[1] = 1; ev_col[31:16] = 16'h9999;
    @(negedge clk); ev_ue = 0;
    rd(2, d); chk("R10 log1 unchanged", d, pk(16'hAB12, 16'h34CD, 3'd2, 2'd1, 8'hC3, 2'b00));
    rd(0, d); chk("R10 status unchanged", d, 0);
    chk("R10 irq low", {63'd0, irq}, 0);
    rd(3, d); chk("R4 unused address", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule